// File: doc/BRIEF.md
# Multi-Speed SCL Phase and SDA Hold Timer

This block paces the clock line of an I2C bus master. It keeps one pair of counts for each of three speed classes: one count for the SCL high phase and one for the SCL low phase. It also keeps a single SDA hold count. All counts are in reference-clock cycles. Software converts nanosecond targets into these counts before it writes them. The block only stores the counts and applies them.

Raising `enable` latches the pair chosen by the 2-bit speed selector, together with the hold count. The timer then alternates between two phases:

- A low phase, during which `scl_drive_low` is asserted.
- A released phase, which starts counting only once the sampled SCL line reads high. A target that holds the clock low therefore stretches the period.

In every low phase, `sda_strobe` pulses once, a programmed number of cycles after SCL fell. This pulse tells the bus sequencer that it may now change SDA.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and on the first cycle following any cycle in which `enable` is sampled low, `scl_drive_low` and `sda_strobe` are both 0.
- R2: The speed code on `speed_sel` is sampled at the rising edge of `enable`. Code 01 picks the standard pair, code 10 the fast pair, and code 11 the pair shared by fast-plus and high-speed operation. Code 00 at enable falls back to the fast pair.
- R3: Each of the three pairs keeps its own high and low values. Writing one pair leaves the other two unchanged.
- R4: A write has `cfg_we` = 1. The field code on `cfg_field` selects the target: 00 is the high count, 01 the low count, 10 the hold count, and 11 writes nothing. A high or low write goes to the pair named by the current `speed_sel`, and is ignored when `speed_sel` is 00. The hold count is shared by all speeds.
- R5: The cycle after `enable` is first sampled high starts a low phase. Each low phase lasts exactly the effective low count, in cycles.
- R6: The released phase lasts the effective high count, counted from the first cycle in which `scl_in` is sampled high. Each cycle that `scl_in` is held low first adds one cycle.
- R7: A stored high or low count of 0 acts as 1.
- R8: `sda_strobe` pulses exactly once per low phase. It fires on cycle index H of that phase, where index 0 is the first low cycle. H is the hold count, clamped to the effective low count minus 1.
- R9: Writes and speed changes made while enabled do not alter the running timing. They take effect at the next rising edge of `enable`.
- R10: Reset values follow from `REF_MHZ`, using cycles = MHz × ns / 1000:
  - standard pair: 4000 ns high, 4700 ns low
  - fast pair: 600 ns high, 1300 ns low
  - shared pair: 260 ns high, 500 ns low (the fast-plus figures)
  - hold: 300 ns

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; its rising edge latches the timing set |
| speed_sel | input | 2 | Speed class code (01 standard, 10 fast, 11 fast-plus/high) |
| cfg_we | input | 1 | Count write strobe |
| cfg_field | input | 2 | Write target: 00 high, 01 low, 10 hold, 11 none |
| cfg_wdata | input | CNT_W | Count value in reference cycles |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 = pull SCL low |
| sda_strobe | output | 1 | One-cycle pulse: SDA may change now |

## Verification
The hardest case to reach from the ports is a stretched high phase. The released phase must wait for the line, and `scl_in` depends on both the block's own drive and on a simulated target. The bench therefore models the line as released only when the block stops pulling it and the model target is not holding it. The target holds SCL low for a programmed number of released samples, and the bench checks that the high phase grows by exactly that amount.

Two other cases are also covered:
- Mid-run writes are made between two measured periods and must leave the second period unchanged.
- A hold count larger than the low phase is programmed, so the clamp can be observed.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    SPD_NONE = 2'b00,
    SPD_STD  = 2'b01,
    SPD_FAST = 2'b10,
    SPD_HIGH = 2'b11
  } speed_e;

  typedef enum logic [1:0] {
    FLD_HIGH = 2'b00,
    FLD_LOW  = 2'b01,
    FLD_HOLD = 2'b10,
    FLD_NONE = 2'b11
  } field_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_WAIT,
    PH_HIGH
  } phase_e;

  localparam int unsigned NUM_MODES = 3;

  // bank index b serves speed code b+1
  function automatic int unsigned high_ns(input int unsigned b);
    case (b)
      0:       return 4000;
      1:       return 600;
      default: return 260;
    endcase
  endfunction

  function automatic int unsigned low_ns(input int unsigned b);
    case (b)
      0:       return 4700;
      1:       return 1300;
      default: return 500;
    endcase
  endfunction

  localparam int unsigned HOLD_NS = 300;

  function automatic int unsigned ns_to_cycles(input int unsigned mhz,
                                               input int unsigned ns);
    return (mhz * ns) / 1000;
  endfunction

endpackage

// File: rtl/scl_cfg_bank.sv
module scl_cfg_bank
  import scl_timing_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned REF_MHZ = 100
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [1:0]                      cfg_field,
  input  logic [CNT_W-1:0]                cfg_wdata,
  input  logic [1:0]                      speed_sel,
  output logic [NUM_MODES-1:0][CNT_W-1:0] hi_q,
  output logic [NUM_MODES-1:0][CNT_W-1:0] lo_q,
  output logic [CNT_W-1:0]                hold_q
);

  localparam logic [CNT_W-1:0] HOLD_RST = CNT_W'(ns_to_cycles(REF_MHZ, HOLD_NS));

  for (genvar b = 0; b < NUM_MODES; b++) begin : g_pair
    localparam logic [CNT_W-1:0] HI_RST = CNT_W'(ns_to_cycles(REF_MHZ, high_ns(b)));
    localparam logic [CNT_W-1:0] LO_RST = CNT_W'(ns_to_cycles(REF_MHZ, low_ns(b)));
    localparam logic [1:0]       CODE   = 2'(b + 1);

    logic [CNT_W-1:0] hi_r, lo_r;
    logic             hit;

    assign hit = cfg_we && (speed_sel == CODE);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_r <= HI_RST;
        lo_r <= LO_RST;
      end else if (hit) begin
        if (cfg_field == FLD_HIGH) hi_r <= cfg_wdata;
        if (cfg_field == FLD_LOW)  lo_r <= cfg_wdata;
      end
    end

    assign hi_q[b] = hi_r;
    assign lo_q[b] = lo_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                hold_q <= HOLD_RST;
    else if (cfg_we && cfg_field == FLD_HOLD)  hold_q <= cfg_wdata;
  end

endmodule

// File: rtl/scl_pair_select.sv
module scl_pair_select
  import scl_timing_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [1:0]                      speed_sel,
  input  logic [NUM_MODES-1:0][CNT_W-1:0] hi_q,
  input  logic [NUM_MODES-1:0][CNT_W-1:0] lo_q,
  input  logic [CNT_W-1:0]                hold_q,
  output logic [CNT_W-1:0]                hi_eff,
  output logic [CNT_W-1:0]                lo_eff,
  output logic [CNT_W-1:0]                hold_eff
);

  logic [CNT_W-1:0] hi_raw, lo_raw;

  always_comb begin
    case (speed_sel)
      SPD_STD:  begin hi_raw = hi_q[0]; lo_raw = lo_q[0]; end
      SPD_HIGH: begin hi_raw = hi_q[2]; lo_raw = lo_q[2]; end
      default:  begin hi_raw = hi_q[1]; lo_raw = lo_q[1]; end
    endcase
  end

  // zero counts are widened to one cycle so the clock can never stall
  assign hi_eff   = (hi_raw == '0) ? CNT_W'(1) : hi_raw;
  assign lo_eff   = (lo_raw == '0) ? CNT_W'(1) : lo_raw;
  assign hold_eff = (hold_q >= lo_eff) ? (lo_eff - CNT_W'(1)) : hold_q;

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_timing_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] hi_eff,
  input  logic [CNT_W-1:0] lo_eff,
  input  logic [CNT_W-1:0] hold_eff,
  output logic             scl_drive_low,
  output logic             sda_strobe
);

  phase_e           phase;
  logic             en_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hi_a, lo_a, hold_a;
  logic             start;

  assign start = enable && !en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      phase  <= PH_IDLE;
      cnt    <= '0;
      hi_a   <= CNT_W'(1);
      lo_a   <= CNT_W'(1);
      hold_a <= '0;
    end else begin
      en_q <= enable;
      if (!enable) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else if (start) begin
        hi_a   <= hi_eff;
        lo_a   <= lo_eff;
        hold_a <= hold_eff;
        phase  <= PH_LOW;
        cnt    <= '0;
      end else begin
        case (phase)
          PH_LOW: begin
            if (cnt == lo_a - CNT_W'(1)) begin
              phase <= PH_WAIT;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_WAIT: begin
            if (scl_in) begin
              if (hi_a == CNT_W'(1)) begin
                phase <= PH_LOW;
                cnt   <= '0;
              end else begin
                phase <= PH_HIGH;
                cnt   <= CNT_W'(1);
              end
            end
          end
          PH_HIGH: begin
            if (cnt == hi_a - CNT_W'(1)) begin
              phase <= PH_LOW;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign scl_drive_low = (phase == PH_LOW);
  assign sda_strobe    = (phase == PH_LOW) && (cnt == hold_a);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned REF_MHZ = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       speed_sel,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_field,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             sda_strobe
);

  logic [NUM_MODES-1:0][CNT_W-1:0] hi_q, lo_q;
  logic [CNT_W-1:0]                hold_q;
  logic [CNT_W-1:0]                hi_eff, lo_eff, hold_eff;

  scl_cfg_bank #(.CNT_W(CNT_W), .REF_MHZ(REF_MHZ)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .speed_sel (speed_sel),
    .hi_q      (hi_q),
    .lo_q      (lo_q),
    .hold_q    (hold_q)
  );

  scl_pair_select #(.CNT_W(CNT_W)) u_sel (
    .speed_sel (speed_sel),
    .hi_q      (hi_q),
    .lo_q      (lo_q),
    .hold_q    (hold_q),
    .hi_eff    (hi_eff),
    .lo_eff    (lo_eff),
    .hold_eff  (hold_eff)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .scl_in        (scl_in),
    .hi_eff        (hi_eff),
    .lo_eff        (lo_eff),
    .hold_eff      (hold_eff),
    .scl_drive_low (scl_drive_low),
    .sda_strobe    (sda_strobe)
  );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_in,
  input logic scl_drive_low,
  input logic sda_strobe
);

  a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !sda_strobe));

  a_r5_low_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> scl_drive_low);

  a_r6_stretch_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drive_low) && enable && $past(enable) && !scl_in) |=> !scl_drive_low);

  a_r8_strobe_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_strobe |-> scl_drive_low);

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sda_strobe |=> !sda_strobe);

endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (.*);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;

  localparam int CNT_W   = 16;
  localparam int REF_MHZ = 100;
  localparam int NV      = 7;

  // per vector: speed, write flag, high, low, hold, stretch, exp low, exp high, exp strobe index
  localparam int V_SPD [NV] = '{1, 2, 3, 3, 1, 2, 1};
  localparam int V_WR  [NV] = '{1, 1, 1, 1, 1, 0, 0};
  localparam int V_HI  [NV] = '{5, 3, 2, 0, 1, 0, 0};
  localparam int V_LO  [NV] = '{7, 4, 3, 0, 2, 0, 0};
  localparam int V_HD  [NV] = '{2, 1, 9, 0, 0, 0, 0};
  localparam int V_STR [NV] = '{0, 3, 0, 0, 5, 0, 2};
  localparam int E_LO  [NV] = '{7, 4, 3, 1, 2, 4, 2};
  localparam int E_HI  [NV] = '{5, 6, 2, 1, 6, 3, 3};
  localparam int E_SI  [NV] = '{2, 1, 2, 0, 0, 0, 0};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic [1:0]       speed_sel = 2'b00;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_field = 2'b11;
  logic [CNT_W-1:0] cfg_wdata = '0;
  logic             stretch = 1'b0;
  logic             scl_in;
  logic             scl_drive_low, sda_strobe;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  assign scl_in = ~scl_drive_low & ~stretch;

  scl_timing_gen #(.CNT_W(CNT_W), .REF_MHZ(REF_MHZ)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .speed_sel(speed_sel),
    .cfg_we(cfg_we), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .sda_strobe(sda_strobe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] fld, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_field = fld; cfg_wdata = CNT_W'(val);
    @(negedge clk);
    cfg_we = 1'b0; cfg_field = 2'b11;
  endtask

  // fresh: called on the negedge enable was raised; otherwise mid-run
  task automatic measure(input bit fresh, input int s,
                         output int lo, output int hi, output int si, output int ns);
    lo = 0; hi = 0; si = -1; ns = 0;
    @(negedge clk);
    if (!fresh) while (scl_drive_low) @(negedge clk);
    while (!scl_drive_low) @(negedge clk);
    stretch = (s > 0);
    while (scl_drive_low) begin
      if (sda_strobe) begin
        if (si < 0) si = lo;
        ns++;
      end
      lo++;
      @(negedge clk);
    end
    while (!scl_drive_low) begin
      hi++;
      if (hi == s + 1) stretch = 1'b0;
      @(negedge clk);
    end
    stretch = 1'b0;
  endtask

  task automatic run_check(input string tag, input bit fresh, input int s,
                           input int elo, input int ehi, input int esi);
    int lo, hi, si, ns;
    measure(fresh, s, lo, hi, si, ns);
    chk({tag, " low length"}, lo, elo);
    chk({tag, " high length"}, hi, ehi);
    chk({tag, " strobe index"}, si, esi);
    chk({tag, " strobe count"}, ns, 1);
  endtask

  task automatic stop_run();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R1 drive released after disable", int'(scl_drive_low), 0);
    chk("R1 strobe quiet after disable", int'(sda_strobe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset drive", int'(scl_drive_low), 0);
    chk("R1 reset strobe", int'(sda_strobe), 0);

    // R10 reset defaults of the shared pair (fast-plus figures) and hold
    speed_sel = 2'b11;
    @(negedge clk);
    enable = 1'b1;
    run_check("R10 default pair", 1'b1, 0,
              REF_MHZ * 500 / 1000, REF_MHZ * 260 / 1000, REF_MHZ * 300 / 1000);
    stop_run();

    // table walk: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      speed_sel = 2'(V_SPD[i]);
      if (V_WR[i] != 0) begin
        wr(2'b00, V_HI[i]);
        wr(2'b01, V_LO[i]);
        wr(2'b10, V_HD[i]);
      end
      @(negedge clk);
      enable = 1'b1;
      run_check($sformatf("R2/R3/R5/R6/R7/R8 vec%0d", i), 1'b1, V_STR[i],
                E_LO[i], E_HI[i], E_SI[i]);
      stop_run();
    end

    // R4: high/low writes with speed code 00 are dropped; 00 at enable uses fast pair (R2)
    speed_sel = 2'b00;
    wr(2'b00, 40);
    wr(2'b01, 41);
    wr(2'b11, 42);
    @(negedge clk);
    enable = 1'b1;
    run_check("R4 writes at speed 00 ignored", 1'b1, 0, 4, 3, 0);
    stop_run();

    // R9: changes while enabled do not disturb the running period
    speed_sel = 2'b10;
    @(negedge clk);
    enable = 1'b1;
    run_check("R9 before change", 1'b1, 0, 4, 3, 0);
    wr(2'b00, 6);
    wr(2'b01, 5);
    wr(2'b10, 2);
    speed_sel = 2'b01;
    run_check("R9 after mid-run change", 1'b0, 0, 4, 3, 0);
    stop_run();
    speed_sel = 2'b10;
    @(negedge clk);
    enable = 1'b1;
    run_check("R9 new values after re-enable", 1'b1, 0, 5, 6, 2);
    stop_run();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule